// File: doc/BRIEF.md
# Port pad pull-up and open-drain controller

This block sits between a small general-purpose port and its pads. It holds two four-bit control registers behind a byte-wide register bus. One register enables a weak pull-up for each pin. The other selects, for each pin, whether an output drives both levels or only pulls low. From these registers and from the port's operating state, the block computes three signals for every pad: output-enable, output value and pull-up enable. The operating state is made up of the mode, the direction bits, the data bits, the address-enable bits and the serial-peripheral ownership bits.

A pin that is selected for address output drives the address value push-pull. This selection is honoured in every mode except the single-chip mode 7. A pin that the serial peripheral has configured as an output drives the peripheral's data. A pin whose direction bit is 1 drives the port data. Every other pin is an input, and only an input may receive a pull-up. The two registers respond differently to reset events. Power-on reset and hardware standby clear both. Manual reset clears only the pull-up register. Software standby freezes both.

Top module: `padctl_port`

## Requirements
- R1: Register offset 0 (`bus_addr`=0) is the pull-up register and offset 1 is the open-drain register. Only bits 3..0 are stored. Writes to bits 7..4 are ignored, and `bus_rdata` bits 7..4 always read 0.
- R2: `bus_rdata` shows the register selected by `bus_addr` without delay. A write presented with `bus_wr`=1 becomes visible only after the next rising clock edge.
- R3: `pad_pu[i]` = 1 exactly when pull-up bit i is 1 and pin i is an input. Pin i is an input when `dir[i]`=0, `ser_out[i]`=0, and it is not an active address pin.
- R4: In modes 0..6, a pin with `addr_en[i]`=1 is an active address pin. It drives `pad_oe`=1 and `pad_o`=`addr_out[i]` with no pull-up, whatever the open-drain, direction and serial settings.
- R5: In mode 7 (`mode`=3'd7), `addr_en` is ignored. Such a pin follows the serial, direction and pull-up rules.
- R6: A driven, non-address pin whose open-drain bit is 1 gives `pad_oe`=1 and `pad_o`=0 when its data is 0, and gives `pad_oe`=0 and `pad_o`=0 when its data is 1.
- R7: A driven, non-address pin whose open-drain bit is 0 gives `pad_oe`=1 and `pad_o` equal to its data.
- R8: An input pin gives `pad_oe`=0 and `pad_o`=0.
- R9: Power-on reset (`rst_n`=0 at a clock edge) clears both registers.
- R10: `hw_stby`=1 at a clock edge clears both registers, and a write made during it is lost.
- R11: `mreset_n`=0 at a clock edge clears the pull-up register and leaves the open-drain register unchanged. Writes made during it are ignored.
- R12: `sw_stby`=1 at a clock edge holds both registers, and a write made during it is ignored.
- R13: A non-address pin with `ser_out[i]`=1 takes `ser_data[i]` as its data. This takes priority over `dir`/`dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mreset_n | input | 1 | Manual reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 pull-up, 1 open-drain |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| mode | input | 3 | Operating mode; 7 is single-chip |
| dir | input | 4 | Direction bits, 1 = output |
| dout | input | 4 | Port data bits |
| addr_en | input | 4 | Address-output select per pin |
| addr_out | input | 4 | Address bus value per pin |
| ser_out | input | 4 | Serial peripheral has the pin as an output |
| ser_data | input | 4 | Serial peripheral output data |
| pad_oe | output | 4 | Pad output-enable |
| pad_o | output | 4 | Pad output value |
| pad_pu | output | 4 | Pad pull-up enable |

## Verification
The assertions assume that `mode`, `dir`, `addr_en`, `ser_out` and the other pin-state inputs are static levels that change only between clock edges. They also assume that the reset and standby inputs are sampled as synchronous levels. The bench drives every input on the falling edge and holds it through the following rising edge, so each clocked property sees settled values. The sweep covers every mode with every combination of the eight per-pin control bits. It keeps the standby inputs low during the sweep and exercises the standby and reset paths in separate, dedicated phases.

// File: rtl/padctl_pkg.sv
// Shared constants and helpers for the port pad controller.
// Assumes a 3-bit mode code where 7 denotes single-chip operation.
package padctl_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 3'd7;
    localparam logic REG_PULLUP = 1'b0;
    localparam logic REG_OPENDR = 1'b1;

    // True when address-enable selections are honoured in this mode.
    function automatic logic addr_mode(input logic [MODE_W-1:0] m);
        return m != MODE_SINGLE;
    endfunction
endpackage

// File: rtl/padctl_regs.sv
// Pull-up and open-drain control registers with their reset and standby rules.
// Assumes all reset and standby inputs are synchronous levels.
// Priority: power-on reset / hardware standby, then manual reset, then software standby, then writes.
module padctl_regs #(
    parameter int NPIN = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mreset_n,
    input  logic            hw_stby,
    input  logic            sw_stby,
    input  logic            wr,
    input  logic            sel,
    input  logic [DW-1:0]   wdata,
    output logic [NPIN-1:0] pu_q,
    output logic [NPIN-1:0] od_q,
    output logic [DW-1:0]   rdata
);
    import padctl_pkg::*;

    localparam int RSV = DW - NPIN;

    logic wr_ok;
    assign wr_ok = wr && mreset_n && !sw_stby;

    // Pull-up register: cleared by every reset kind, held in software standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby || !mreset_n)
            pu_q <= '0;
        else if (wr_ok && sel == REG_PULLUP)
            pu_q <= wdata[NPIN-1:0];
    end

    // Open-drain register: survives manual reset, held in software standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby)
            od_q <= '0;
        else if (wr_ok && sel == REG_OPENDR)
            od_q <= wdata[NPIN-1:0];
    end

    // Read mux: reserved upper bits read as zero.
    always_comb begin
        rdata = {{RSV{1'b0}}, (sel == REG_OPENDR) ? od_q : pu_q};
    end
endmodule

// File: rtl/padctl_pin.sv
// Pad logic for one pin: picks the driver, applies open-drain and pull-up rules.
// Assumes addr_act already folds the mode qualification into address-enable.
module padctl_pin (
    input  logic addr_act,
    input  logic addr_val,
    input  logic ser_own,
    input  logic ser_val,
    input  logic dir_out,
    input  logic dat,
    input  logic od_bit,
    input  logic pu_bit,
    output logic oe,
    output logic o,
    output logic pu
);
    logic drive;
    logic val;

    // Source selection: serial peripheral takes priority over port direction.
    always_comb begin
        drive = ser_own || dir_out;
        val   = ser_own ? ser_val : dat;
    end

    // Pad outputs: address push-pull, then open-drain or push-pull, else input.
    always_comb begin
        oe = 1'b0;
        o  = 1'b0;
        pu = 1'b0;
        if (addr_act) begin
            oe = 1'b1;
            o  = addr_val;
        end else if (drive) begin
            if (od_bit) begin
                oe = !val;
                o  = 1'b0;
            end else begin
                oe = 1'b1;
                o  = val;
            end
        end else begin
            pu = pu_bit;
        end
    end
endmodule

// File: rtl/padctl_port.sv
// Top of the port pad controller: register block plus one pad slice per pin.
// Assumes mode and pin-state inputs are static levels between edges.
module padctl_port #(
    parameter int NPIN = 4,
    parameter int DW   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mreset_n,
    input  logic                        hw_stby,
    input  logic                        sw_stby,
    input  logic                        bus_wr,
    input  logic                        bus_addr,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    input  logic [padctl_pkg::MODE_W-1:0] mode,
    input  logic [NPIN-1:0]             dir,
    input  logic [NPIN-1:0]             dout,
    input  logic [NPIN-1:0]             addr_en,
    input  logic [NPIN-1:0]             addr_out,
    input  logic [NPIN-1:0]             ser_out,
    input  logic [NPIN-1:0]             ser_data,
    output logic [NPIN-1:0]             pad_oe,
    output logic [NPIN-1:0]             pad_o,
    output logic [NPIN-1:0]             pad_pu
);
    import padctl_pkg::*;

    logic [NPIN-1:0] pu_q;
    logic [NPIN-1:0] od_q;
    logic            ext;

    // Mode qualification for address-enable selections.
    assign ext = addr_mode(mode);

    padctl_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mreset_n (mreset_n),
        .hw_stby  (hw_stby),
        .sw_stby  (sw_stby),
        .wr       (bus_wr),
        .sel      (bus_addr),
        .wdata    (bus_wdata),
        .pu_q     (pu_q),
        .od_q     (od_q),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        padctl_pin u_pin (
            .addr_act (addr_en[i] && ext),
            .addr_val (addr_out[i]),
            .ser_own  (ser_out[i]),
            .ser_val  (ser_data[i]),
            .dir_out  (dir[i]),
            .dat      (dout[i]),
            .od_bit   (od_q[i]),
            .pu_bit   (pu_q[i]),
            .oe       (pad_oe[i]),
            .o        (pad_o[i]),
            .pu       (pad_pu[i])
        );
    end
endmodule

// File: rtl/padctl_port_chk.sv
// Property checker for padctl_port, attached by bind; observes ports and register state.
module padctl_port_chk #(
    parameter int NPIN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mreset_n,
    input logic            hw_stby,
    input logic            sw_stby,
    input logic [2:0]      mode,
    input logic [NPIN-1:0] dir,
    input logic [NPIN-1:0] addr_en,
    input logic [NPIN-1:0] addr_out,
    input logic [NPIN-1:0] ser_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_o,
    input logic [NPIN-1:0] pad_pu,
    input logic [NPIN-1:0] pu_q,
    input logic [NPIN-1:0] od_q
);
    logic [NPIN-1:0] act_addr;
    assign act_addr = addr_en & {NPIN{mode != 3'd7}};

    AST_PU_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & (dir | ser_out | act_addr)) == '0); // R3
    AST_ADDR_PUSHPULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & act_addr) == act_addr) && (((pad_o ^ addr_out) & act_addr) == '0)); // R4
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_o & od_q & ~act_addr) == '0); // R6
    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_o) & ~(dir | ser_out | act_addr)) == '0); // R8
    AST_HWSTBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pu_q == '0) && (od_q == '0)); // R10
    AST_MRESET_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreset_n && !hw_stby) |=> (pu_q == '0) && $stable(od_q)); // R11
    AST_SWSTBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && mreset_n && !hw_stby) |=> $stable(pu_q) && $stable(od_q)); // R12
endmodule

bind padctl_port padctl_port_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mreset_n (mreset_n),
    .hw_stby  (hw_stby),
    .sw_stby  (sw_stby),
    .mode     (mode),
    .dir      (dir),
    .addr_en  (addr_en),
    .addr_out (addr_out),
    .ser_out  (ser_out),
    .pad_oe   (pad_oe),
    .pad_o    (pad_o),
    .pad_pu   (pad_pu),
    .pu_q     (pu_q),
    .od_q     (od_q)
);

// File: tb/padctl_port_test.sv
// Self-checking bench: register and reset phases, then a sweep over all modes
// and all combinations of the eight per-pin control bits.
module padctl_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mreset_n = 1'b1;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] mode = '0;
    logic [3:0] dir = '0, dout = '0, addr_en = '0, addr_out = '0, ser_out = '0, ser_data = '0;
    logic [3:0] pad_oe, pad_o, pad_pu;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    padctl_port uut (
        .clk(clk), .rst_n(rst_n), .mreset_n(mreset_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode(mode), .dir(dir), .dout(dout), .addr_en(addr_en), .addr_out(addr_out),
        .ser_out(ser_out), .ser_data(ser_data), .pad_oe(pad_oe), .pad_o(pad_o), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Expected {oe, o, pu} for one pin, from the requirements.
    function automatic logic [2:0] model(input logic [2:0] m, input logic [7:0] c);
        logic pu, od, dr, dt, ae, ao, so, sd, act, drv, v;
        {sd, so, ao, ae, dt, dr, od, pu} = c;
        act = ae & (m != 3'd7);
        drv = so | dr;
        v   = so ? sd : dt;
        if (act) return {1'b1, ao, 1'b0};
        if (drv) return od ? {~v, 1'b0, 1'b0} : {1'b1, v, 1'b0};
        return {1'b0, 1'b0, pu};
    endfunction

    function automatic string tag(input logic [2:0] m, input logic [7:0] c);
        if (c[4] && m != 3'd7) return "R4";
        if (c[4]) return "R5";
        if (c[6]) return "R13";
        if (c[2]) return c[1] ? "R6" : "R7";
        return "R3/R8";
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        rd(1'b0, r); check("R9 pull-up after reset", {4'h0, r}, 12'h000);
        rd(1'b1, r); check("R9 open-drain after reset", {4'h0, r}, 12'h000);
        // R1: reserved bits
        wr(1'b0, 8'hFF); rd(1'b0, r); check("R1 pull-up FF", {4'h0, r}, 12'h00F);
        wr(1'b1, 8'hA5); rd(1'b1, r); check("R1 open-drain A5", {4'h0, r}, 12'h005);
        // R2: write visible only after the edge
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h0A;
        #1 check("R2 before edge", {4'h0, bus_rdata}, 12'h005);
        @(negedge clk); bus_wr = 1'b0;
        rd(1'b1, r); check("R2 after edge", {4'h0, r}, 12'h00A);
        // R11: manual reset
        wr(1'b0, 8'h0F);
        @(negedge clk); mreset_n = 1'b0; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h03;
        @(negedge clk); mreset_n = 1'b1; bus_wr = 1'b0;
        rd(1'b0, r); check("R11 pull-up cleared", {4'h0, r}, 12'h000);
        rd(1'b1, r); check("R11 open-drain kept, write ignored", {4'h0, r}, 12'h00A);
        // R12: software standby
        wr(1'b0, 8'h06);
        @(negedge clk); sw_stby = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h09;
        @(negedge clk); bus_addr = 1'b1;
        @(negedge clk); sw_stby = 1'b0; bus_wr = 1'b0;
        rd(1'b0, r); check("R12 pull-up held", {4'h0, r}, 12'h006);
        rd(1'b1, r); check("R12 open-drain held", {4'h0, r}, 12'h00A);
        // R10: hardware standby
        @(negedge clk); hw_stby = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h0C;
        @(negedge clk); hw_stby = 1'b0; bus_wr = 1'b0;
        rd(1'b0, r); check("R10 pull-up cleared", {4'h0, r}, 12'h000);
        rd(1'b1, r); check("R10 open-drain cleared", {4'h0, r}, 12'h000);
        // R9: power-on reset clears values written afterwards
        wr(1'b0, 8'h05); wr(1'b1, 8'h0B);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(1'b0, r); check("R9 pull-up after POR", {4'h0, r}, 12'h000);
        rd(1'b1, r); check("R9 open-drain after POR", {4'h0, r}, 12'h000);
        // Sweep: every mode, every per-pin combination, pins rotated.
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 256; c++) begin
                logic [7:0] cp [4];
                logic [3:0] vpu, vod;
                for (int i = 0; i < 4; i++) cp[i] = 8'(c + 61 * i);
                for (int i = 0; i < 4; i++) begin
                    vpu[i] = cp[i][0]; vod[i] = cp[i][1];
                end
                wr(1'b0, {4'hF, vpu});
                wr(1'b1, {4'hF, vod});
                mode = 3'(m);
                for (int i = 0; i < 4; i++) begin
                    dir[i] = cp[i][2]; dout[i] = cp[i][3]; addr_en[i] = cp[i][4];
                    addr_out[i] = cp[i][5]; ser_out[i] = cp[i][6]; ser_data[i] = cp[i][7];
                end
                #1;
                for (int i = 0; i < 4; i++)
                    check(tag(3'(m), cp[i]), {9'h0, pad_oe[i], pad_o[i], pad_pu[i]},
                          {9'h0, model(3'(m), cp[i])});
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule